// File: doc/BRIEF.md
# One-Wire ROM Search Sequencer

This block enumerates the 64-bit identifiers of every device on a One-Wire bus, one identifier per search request. It sits above a bit engine that owns all slot timing. The sequencer only asks the engine for a bus reset, a write slot or a read slot, and then waits for the engine to report that the slot is over.

A pass begins with a bus reset and the search command byte. It then walks the 64 identifier positions. At each position it reads the true bit, then its complement, and writes back the branch it chose. When both reads are 0, two or more devices disagree at that position. The branch is then taken from the discrepancy stored by the previous pass and from the previous identifier, so that successive passes walk the binary tree of identifiers. After the last device has been found, the block marks itself finished and answers further requests with an empty result. A clear input restarts the enumeration.

Top module: `ow_rom_search`

## Requirements
- R1: An accepted pass first issues one reset operation (cmd_op 0). It then issues 8 write operations (cmd_op 1) that carry the byte 0xF0, least significant bit first.
- R2: For each of the 64 positions, in ascending order, the block issues two reads (cmd_op 2) and then one write. The first read returns the true bit and the second returns its complement. Each operation ends on the cycle where eng_done is high.
- R3: If the true bit is 0 and the complement is 1, the written bit is 0. If the true bit is 1 and the complement is 0, the written bit is 1.
- R4: If both reads return 1, the pass stops. done and no_dev pulse together for one cycle, finished becomes 1, and rom_id keeps its old value.
- R5: When both reads return 0, the written bit depends on the stored discrepancy. If no discrepancy is stored, the bit is 0. Below the stored position, the bit is the previous identifier's bit at that position. At the stored position, the bit is 1. Above the stored position, the bit is 0.
- R6: The highest position at which a both-zero read was answered with a 0 is stored as the discrepancy for the next pass. This includes position 0. If no such position exists, no discrepancy is stored.
- R7: After position 63, rom_id holds the written bits, with the bit written at position i in rom_id[i]. done and rom_valid pulse together for one cycle. finished becomes 1 exactly when no discrepancy was stored in that pass.
- R8: A request while finished is 1 makes done pulse alone one cycle later, and no bus operation is issued.
- R9: clear_state while busy is low clears finished, rom_id and the stored discrepancy on the next edge, and the next request restarts from the first identifier. clear_state takes priority over a request in the same cycle.
- R10: After reset, rom_id is 0 and cmd_valid, busy, done, rom_valid, no_dev and finished are all 0.
- R11: busy rises only after an accepted request and falls when the result is reported. cmd_valid is high only while busy is high. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_req | input | 1 | Request one search pass (sampled while idle) |
| clear_state | input | 1 | Restart the enumeration (honoured while idle) |
| cmd_valid | output | 1 | Operation request to the bit engine, held until eng_done |
| cmd_op | output | 2 | Operation: 0 reset, 1 write, 2 read |
| cmd_bit | output | 1 | Bit to write for a write operation |
| eng_done | input | 1 | One-cycle pulse: the current operation is complete |
| eng_rbit | input | 1 | Sampled bus bit for a read, valid with eng_done |
| rom_id | output | 64 | Last identifier found |
| finished | output | 1 | Enumeration complete or bus empty |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse: a request has been answered |
| rom_valid | output | 1 | With done: rom_id holds a new identifier |
| no_dev | output | 1 | With done: the pass ended with no responding device |

## Verification
A corrupted stored discrepancy, or a stale copy of the previous identifier, does not show up on the pass where it arises. It shows up on the next pass: the wrong branch is taken, so an identifier is repeated or skipped, or finished is set one pass early or late. It is caught at the done pulse that ends that pass. A wrong branch bit inside a pass desynchronises the device model, so the wrong identifier, or a no_dev abort, appears at that same pass's done pulse. A broken command byte or slot order breaks the model's phase tracking, so it is caught at the end of the first pass.

// File: rtl/ows_pkg.sv
package ows_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } ow_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_CMD,
    S_RDT,
    S_RDC,
    S_CHK,
    S_WR,
    S_FIN
  } seq_st_e;

endpackage

// File: rtl/ows_branch.sv
// Combinational branch choice for one identifier position.
module ows_branch #(
  parameter int ROM_W = 64,
  parameter int IDX_W = $clog2(ROM_W)
) (
  input  logic             t_bit,
  input  logic             c_bit,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] last_disc,
  input  logic             last_vld,
  input  logic             prev_bit,
  output logic             dir,
  output logic             zero_br,
  output logic             abort
);

  always_comb begin
    abort   = t_bit & c_bit;
    zero_br = 1'b0;
    dir     = 1'b1;
    if (t_bit != c_bit) begin
      dir = t_bit;
    end else if (!t_bit) begin
      // Both reads 0: devices disagree at this position.
      if (!last_vld) begin
        dir = 1'b0;
      end else if (idx < last_disc) begin
        dir = prev_bit;
      end else if (idx == last_disc) begin
        dir = 1'b1;
      end else begin
        dir = 1'b0;
      end
      zero_br = ~dir;
    end
  end

endmodule

// File: rtl/ows_ctrl.sv
// Pass sequencing: reset, command byte, then read/read/write per position.
module ows_ctrl
  import ows_pkg::*;
#(
  parameter int          ROM_W    = 64,
  parameter int          CMD_W    = 8,
  parameter logic [7:0]  CMD_CODE = 8'hF0,
  parameter int          IDX_W    = $clog2(ROM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_req,
  input  logic             clear_state,
  input  logic             finished,
  input  logic             eng_done,
  input  logic             eng_rbit,
  input  logic             abort,
  input  logic             dir,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic             cmd_bit,
  output logic [IDX_W-1:0] idx,
  output logic             t_bit,
  output logic             c_bit,
  output logic             ev_start,
  output logic             ev_commit,
  output logic             ev_ok,
  output logic             ev_abort,
  output logic             ev_empty,
  output logic             busy
);

  localparam int CMD_IW = (CMD_W > 1) ? $clog2(CMD_W) : 1;
  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] POS_LAST = IDX_W'(ROM_W - 1);

  seq_st_e          state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             t_q, t_d, c_q, c_d;
  logic             cnt_en, t_en, c_en;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    t_d       = t_q;
    c_d       = c_q;
    ev_start  = 1'b0;
    ev_commit = 1'b0;
    ev_ok     = 1'b0;
    ev_abort  = 1'b0;
    ev_empty  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (search_req && !clear_state) begin
          if (finished) begin
            ev_empty = 1'b1;
          end else begin
            ev_start = 1'b1;
            state_d  = S_RST;
          end
        end
      end
      S_RST: begin
        if (eng_done) begin
          state_d = S_CMD;
          cnt_d   = '0;
        end
      end
      S_CMD: begin
        if (eng_done) begin
          if (cnt_q == CMD_LAST) begin
            state_d = S_RDT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_RDT: begin
        if (eng_done) begin
          t_d     = eng_rbit;
          state_d = S_RDC;
        end
      end
      S_RDC: begin
        if (eng_done) begin
          c_d     = eng_rbit;
          state_d = S_CHK;
        end
      end
      S_CHK: begin
        if (abort) begin
          ev_abort = 1'b1;
          state_d  = S_IDLE;
        end else begin
          state_d = S_WR;
        end
      end
      S_WR: begin
        if (eng_done) begin
          ev_commit = 1'b1;
          if (cnt_q == POS_LAST) begin
            state_d = S_FIN;
          end else begin
            cnt_d   = cnt_q + 1'b1;
            state_d = S_RDT;
          end
        end
      end
      S_FIN: begin
        ev_ok   = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign cnt_en = (cnt_d != cnt_q);
  assign t_en   = (state_q == S_RDT) && eng_done;
  assign c_en   = (state_q == S_RDC) && eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      t_q     <= 1'b0;
      c_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (t_en)   t_q   <= t_d;
      if (c_en)   c_q   <= c_d;
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_RESET;
    cmd_bit   = 1'b0;
    case (state_q)
      S_RST: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_RESET;
      end
      S_CMD: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WRITE;
        cmd_bit   = CMD_CODE[cnt_q[CMD_IW-1:0]];
      end
      S_RDT, S_RDC: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_READ;
      end
      S_WR: begin
        cmd_valid = 1'b1;
        cmd_op    = OP_WRITE;
        cmd_bit   = dir;
      end
      default: ;
    endcase
  end

  assign idx   = cnt_q;
  assign t_bit = t_q;
  assign c_bit = c_q;
  assign busy  = (state_q != S_IDLE);

endmodule

// File: rtl/ows_track.sv
// Identifier assembly, zero-branch tracking and state kept between passes.
module ows_track #(
  parameter int ROM_W = 64,
  parameter int IDX_W = $clog2(ROM_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_start,
  input  logic             ev_commit,
  input  logic             ev_ok,
  input  logic             ev_abort,
  input  logic             ev_empty,
  input  logic             dir,
  input  logic             zero_br,
  input  logic [IDX_W-1:0] idx,
  output logic [ROM_W-1:0] rom_id,
  output logic [IDX_W-1:0] last_disc,
  output logic             last_vld,
  output logic             finished,
  output logic             prev_bit,
  output logic             done,
  output logic             rom_valid,
  output logic             no_dev
);

  logic [ROM_W-1:0] acc_q, acc_d, rom_q, rom_d;
  logic [IDX_W-1:0] zpos_q, zpos_d, ld_q, ld_d;
  logic             zvld_q, zvld_d, ldv_q, ldv_d, fin_q, fin_d;
  logic             done_q, done_d, rv_q, rv_d, nd_q, nd_d;
  logic             acc_en, res_en;

  always_comb begin
    acc_d  = acc_q;
    zpos_d = zpos_q;
    zvld_d = zvld_q;
    if (ev_start) begin
      acc_d  = '0;
      zpos_d = '0;
      zvld_d = 1'b0;
    end else if (ev_commit) begin
      acc_d = {dir, acc_q[ROM_W-1:1]};
      if (zero_br) begin
        zpos_d = idx;
        zvld_d = 1'b1;
      end
    end
  end

  always_comb begin
    rom_d = rom_q;
    ld_d  = ld_q;
    ldv_d = ldv_q;
    fin_d = fin_q;
    if (clr) begin
      rom_d = '0;
      ld_d  = '0;
      ldv_d = 1'b0;
      fin_d = 1'b0;
    end else if (ev_ok) begin
      rom_d = acc_q;
      ld_d  = zpos_q;
      ldv_d = zvld_q;
      fin_d = ~zvld_q;
    end else if (ev_abort) begin
      fin_d = 1'b1;
    end
  end

  assign done_d = ev_ok | ev_abort | ev_empty;
  assign rv_d   = ev_ok;
  assign nd_d   = ev_abort;
  assign acc_en = ev_start | ev_commit;
  assign res_en = clr | ev_ok | ev_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      zpos_q <= '0;
      zvld_q <= 1'b0;
      rom_q  <= '0;
      ld_q   <= '0;
      ldv_q  <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      nd_q   <= 1'b0;
    end else begin
      if (acc_en) begin
        acc_q  <= acc_d;
        zpos_q <= zpos_d;
        zvld_q <= zvld_d;
      end
      if (res_en) begin
        rom_q <= rom_d;
        ld_q  <= ld_d;
        ldv_q <= ldv_d;
        fin_q <= fin_d;
      end
      done_q <= done_d;
      rv_q   <= rv_d;
      nd_q   <= nd_d;
    end
  end

  assign rom_id    = rom_q;
  assign last_disc = ld_q;
  assign last_vld  = ldv_q;
  assign finished  = fin_q;
  assign prev_bit  = rom_q[idx];
  assign done      = done_q;
  assign rom_valid = rv_q;
  assign no_dev    = nd_q;

endmodule

// File: rtl/ow_rom_search.sv
module ow_rom_search #(
  parameter int         ROM_W    = 64,
  parameter int         CMD_W    = 8,
  parameter logic [7:0] CMD_CODE = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_req,
  input  logic             clear_state,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic             cmd_bit,
  input  logic             eng_done,
  input  logic             eng_rbit,
  output logic [ROM_W-1:0] rom_id,
  output logic             finished,
  output logic             busy,
  output logic             done,
  output logic             rom_valid,
  output logic             no_dev
);

  localparam int IDX_W = $clog2(ROM_W);

  logic [IDX_W-1:0] idx, last_disc;
  logic             last_vld, prev_bit, t_bit, c_bit;
  logic             dir, zero_br, abort;
  logic             ev_start, ev_commit, ev_ok, ev_abort, ev_empty;
  logic             clr;

  assign clr = clear_state & ~busy;

  ows_ctrl #(
    .ROM_W(ROM_W), .CMD_W(CMD_W), .CMD_CODE(CMD_CODE), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .search_req(search_req), .clear_state(clear_state),
    .finished(finished),
    .eng_done(eng_done), .eng_rbit(eng_rbit),
    .abort(abort), .dir(dir),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .idx(idx), .t_bit(t_bit), .c_bit(c_bit),
    .ev_start(ev_start), .ev_commit(ev_commit), .ev_ok(ev_ok),
    .ev_abort(ev_abort), .ev_empty(ev_empty),
    .busy(busy)
  );

  ows_branch #(.ROM_W(ROM_W), .IDX_W(IDX_W)) u_branch (
    .t_bit(t_bit), .c_bit(c_bit), .idx(idx),
    .last_disc(last_disc), .last_vld(last_vld), .prev_bit(prev_bit),
    .dir(dir), .zero_br(zero_br), .abort(abort)
  );

  ows_track #(.ROM_W(ROM_W), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ev_start(ev_start), .ev_commit(ev_commit), .ev_ok(ev_ok),
    .ev_abort(ev_abort), .ev_empty(ev_empty),
    .dir(dir), .zero_br(zero_br), .idx(idx),
    .rom_id(rom_id), .last_disc(last_disc), .last_vld(last_vld),
    .finished(finished), .prev_bit(prev_bit),
    .done(done), .rom_valid(rom_valid), .no_dev(no_dev)
  );

endmodule

// File: rtl/ows_search_chk.sv
module ows_search_chk #(
  parameter int ROM_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             search_req,
  input logic             clear_state,
  input logic             cmd_valid,
  input logic             busy,
  input logic             done,
  input logic             rom_valid,
  input logic             no_dev,
  input logic             finished,
  input logic [ROM_W-1:0] rom_id
);

  // R11
  cmd_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  // R11
  start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(search_req));

  // R7
  ok_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_valid |-> (done && !no_dev && !busy));

  // R4
  abort_sets_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_dev |-> (done && finished && !busy));

  // R4
  rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rom_id));

  // R8
  empty_when_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rom_valid && !no_dev) |-> finished);

  // R9
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_state && !busy) |-> (!finished && rom_id == '0));

endmodule

bind ow_rom_search ows_search_chk #(.ROM_W(ROM_W)) u_search_chk (
  .clk(clk), .rst_n(rst_n), .search_req(search_req),
  .clear_state(clear_state), .cmd_valid(cmd_valid), .busy(busy),
  .done(done), .rom_valid(rom_valid), .no_dev(no_dev),
  .finished(finished), .rom_id(rom_id)
);

// File: tb/ow_rom_search_test.sv
`timescale 1ns/1ps
module ow_rom_search_test;

  logic        clk;
  logic        rst_n;
  logic        search_req;
  logic        clear_state;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_bit;
  logic        eng_done;
  logic        eng_rbit;
  logic [63:0] rom_id;
  logic        finished, busy, done, rom_valid, no_dev;

  ow_rom_search uut (
    .clk(clk), .rst_n(rst_n), .search_req(search_req),
    .clear_state(clear_state), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bit(cmd_bit), .eng_done(eng_done), .eng_rbit(eng_rbit),
    .rom_id(rom_id), .finished(finished), .busy(busy), .done(done),
    .rom_valid(rom_valid), .no_dev(no_dev)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- device model on the bus ----------------
  logic [63:0] dev_rom [4];
  int          dev_n;
  bit          dev_act [4];
  int          n_reset = 0;
  int          n_ops   = 0;
  int          cmd_wr;
  logic [7:0]  cmd_seen;
  int          pos;
  int          rd_step;

  function automatic bit bus_read(input bit comp);
    bit r = 1'b1;
    for (int k = 0; k < 4; k++)
      if (dev_act[k] && pos < 64)
        r = r & (comp ? ~dev_rom[k][pos] : dev_rom[k][pos]);
    return r;
  endfunction

  initial begin
    eng_done = 1'b0;
    eng_rbit = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        logic [1:0] op;
        logic       wb;
        logic       rb;
        op = cmd_op;
        wb = cmd_bit;
        rb = 1'b0;
        n_ops++;
        repeat (2) @(negedge clk);
        case (op)
          2'd0: begin
            n_reset++;
            for (int k = 0; k < 4; k++) dev_act[k] = (k < dev_n);
            cmd_wr   = 0;
            cmd_seen = 8'h00;
            pos      = 0;
            rd_step  = 0;
          end
          2'd1: begin
            if (cmd_wr < 8) begin
              cmd_seen[cmd_wr] = wb;
              cmd_wr++;
            end else begin
              for (int k = 0; k < 4; k++)
                if (dev_act[k] && pos < 64 && dev_rom[k][pos] != wb)
                  dev_act[k] = 1'b0;
              pos++;
              rd_step = 0;
            end
          end
          default: begin
            rb = bus_read(rd_step == 1);
            rd_step++;
          end
        endcase
        eng_rbit = rb;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  // ---------------- reference of the enumeration rules ----------------
  typedef struct {
    int          kind;   // 0 empty, 1 identifier, 2 no device
    logic [63:0] rom;
    bit          fin;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] ref_rom;
  int          ref_ld;
  bit          ref_lv;
  bit          ref_fin;

  task automatic ref_clear();
    ref_rom = '0; ref_ld = 0; ref_lv = 0; ref_fin = 0;
  endtask

  task automatic ref_step(output exp_t e);
    bit          act [4];
    logic [63:0] r;
    int          zp;
    bit          zv;
    e.rom = ref_rom;
    if (ref_fin) begin
      e.kind = 0; e.fin = 1; return;
    end
    for (int k = 0; k < 4; k++) act[k] = (k < dev_n);
    r = '0; zp = 0; zv = 0;
    for (int i = 0; i < 64; i++) begin
      bit t = 1, c = 1, d;
      for (int k = 0; k < 4; k++)
        if (act[k]) begin
          t = t & dev_rom[k][i];
          c = c & ~dev_rom[k][i];
        end
      if (t && c) begin           // R4 abort
        ref_fin = 1; e.kind = 2; e.fin = 1; return;
      end
      if (t != c) d = t;          // R3
      else begin                  // R5
        if (!ref_lv)          d = 0;
        else if (i < ref_ld)  d = ref_rom[i];
        else if (i == ref_ld) d = 1;
        else                  d = 0;
        if (!d) begin zp = i; zv = 1; end   // R6
      end
      r[i] = d;
      for (int k = 0; k < 4; k++)
        if (act[k] && dev_rom[k][i] != d) act[k] = 0;
    end
    ref_rom = r; ref_ld = zp; ref_lv = zv; ref_fin = !zv;
    e.kind = 1; e.rom = r; e.fin = !zv;
  endtask

  // ---------------- monitor / scoreboard ----------------
  logic [63:0] found [8];
  int          n_found;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rom_valid == (e.kind == 1), "R7", "rom_valid", 64'(rom_valid), 64'(e.kind == 1));
          chk(no_dev == (e.kind == 2), "R4", "no_dev", 64'(no_dev), 64'(e.kind == 2));
          chk(rom_id == e.rom, (e.kind == 1) ? "R5" : "R4", "rom_id", rom_id, e.rom);
          chk(finished == e.fin, "R6", "finished", 64'(finished), 64'(e.fin));
          if (e.kind == 1 && n_found < 8) begin
            found[n_found] = rom_id;
            n_found++;
          end
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic search_once(input bit poke);
    exp_t e;
    int   r0, o0;
    ref_step(e);
    exp_q.push_back(e);
    r0 = n_reset;
    o0 = n_ops;
    @(negedge clk); search_req = 1'b1;
    @(negedge clk); search_req = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R11", "busy mid-pass", 64'(busy), 64'd1);
      search_req = 1'b1;
      @(negedge clk); search_req = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    if (e.kind == 0) begin
      chk(n_ops == o0, "R8", "bus ops on empty request", 64'(n_ops - o0), 64'd0);
    end else begin
      chk(n_reset == r0 + 1, "R1", "one reset per pass", 64'(n_reset - r0), 64'd1);
      chk(cmd_seen == 8'hF0, "R1", "command byte", 64'(cmd_seen), 64'hF0);
      if (e.kind == 1)
        chk(n_ops == o0 + 1 + 8 + 64 * 3, "R2", "ops per pass", 64'(n_ops - o0), 64'(201));
      else
        chk(n_ops == o0 + 1 + 8 + 2, "R4", "ops before abort", 64'(n_ops - o0), 64'd11);
    end
    if (poke)
      chk(busy == 1'b0, "R11", "second request ignored", 64'(busy), 64'd0);
  endtask

  task automatic clear_all();
    @(negedge clk); clear_state = 1'b1; search_req = 1'b1;
    @(negedge clk); clear_state = 1'b0; search_req = 1'b0;
    ref_clear();
    @(negedge clk);
    chk(finished == 1'b0 && rom_id == '0 && busy == 1'b0, "R9", "cleared state",
        {rom_id[62:0], finished}, 64'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    search_req  = 1'b0;
    clear_state = 1'b0;
    rst_n       = 1'b0;
    dev_n       = 0;
    n_found     = 0;
    for (int k = 0; k < 4; k++) dev_rom[k] = '0;
    ref_clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(rom_id == '0, "R10", "rom_id", rom_id, 64'd0);
    chk({cmd_valid, busy, done, rom_valid, no_dev, finished} == 6'd0, "R10", "flags",
        64'({cmd_valid, busy, done, rom_valid, no_dev, finished}), 64'd0);

    // Set A: discrepancies at positions 0 and 63 (R5, R6)
    dev_rom[0] = 64'h0000_0000_0000_00A5;
    dev_rom[1] = 64'h8000_0000_0000_00A5;
    dev_rom[2] = 64'h0000_0000_0000_00A4;
    dev_n = 3;
    for (int p = 0; p < 3; p++) search_once(1'b0);
    chk(finished == 1'b1, "R7", "finished after last device", 64'(finished), 64'd1);
    chk(n_found == 3, "R6", "devices found", 64'(n_found), 64'd3);
    for (int f = 0; f < 3; f++) begin
      bit hit = 0;
      for (int k = 0; k < 3; k++) if (found[f] == dev_rom[k]) hit = 1;
      for (int g = 0; g < f; g++) if (found[g] == found[f]) hit = 0;
      chk(hit, "R5", "identifier distinct and present", found[f], 64'd0);
    end
    chk(found[0] == 64'h0000_0000_0000_00A4, "R6", "zero branch at position 0 first",
        found[0], 64'h00A4);
    search_once(1'b0);            // R8 empty result

    // Set D: four devices in the two low bits
    clear_all();
    dev_rom[0] = 64'h0; dev_rom[1] = 64'h1; dev_rom[2] = 64'h2; dev_rom[3] = 64'h3;
    dev_n = 4;
    for (int p = 0; p < 4; p++) search_once(1'b0);
    search_once(1'b0);

    // Set B: single device, request while busy (R11)
    clear_all();
    dev_rom[0] = 64'hDEAD_BEEF_0123_4567;
    dev_n = 1;
    search_once(1'b1);
    chk(finished == 1'b1, "R7", "single device finishes", 64'(finished), 64'd1);
    search_once(1'b0);

    // Set C: empty bus (R4)
    clear_all();
    dev_n = 0;
    search_once(1'b0);
    chk(finished == 1'b1, "R4", "finished after no device", 64'(finished), 64'd1);
    search_once(1'b0);

    // R9: enumeration restarts from the first identifier
    clear_all();
    dev_rom[0] = 64'h0000_0000_0000_00A5;
    dev_rom[1] = 64'h8000_0000_0000_00A5;
    dev_rom[2] = 64'h0000_0000_0000_00A4;
    dev_n = 3;
    search_once(1'b0);
    chk(rom_id == 64'h0000_0000_0000_00A4, "R9", "restart first identifier",
        rom_id, 64'h00A4);

    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule